// File: doc/BRIEF.md
# Windowed Stack Frame Sequencer

This block owns a 16-bit stack pointer and moves multi-byte stack frames over a byte-wide memory port, one byte per clock. Three commands save a frame (register-pair save, subroutine call, interrupt entry). Three commands restore one (register-pair restore, subroutine return, interrupt return). Each command has a fixed frame length of two or three bytes and a fixed byte order. The pointer can never leave a 1 KB on-chip RAM window spanning 0xFB00 to 0xFEFF. A loaded value is folded into that window, and stepping past either end of the window wraps to the opposite end.

A core drives a command code together with a 16-bit word (a register pair or return address) and an 8-bit status byte. The block then runs the frame on its own and asserts busy while it does so. It pulses done when the frame is finished. Restored words and status are presented on dedicated outputs. The memory read path is combinational: read data must be valid in the same cycle as the read strobe. The pointer is undefined until software loads it, so all commands are refused until the first load.

Top module: `stack_frame_seq`

## Requirements
- R1: A pointer load keeps only the low 10 bits of the value. It sets the pointer to 0xFB00 + ((value − 0xFB00) mod 1024), and sp_value always shows this folded address. For example, 0xFF00 gives 0xFB00, 0x0301 gives 0xFB01 and 0x2AFF gives 0xFEFF.
- R2: After reset, sp_ready is 0, busy and done are 0, and every command is ignored until the first pointer load. An ignored command produces no memory access and no done.
- R3: A save frame decrements the pointer before each byte write and writes that byte at the new pointer. The final pointer is the start value minus the frame length.
- R4: Interrupt entry (cmd_op 3) writes three bytes in this order: cmd_stat at SP−1, cmd_word[15:8] at SP−2, cmd_word[7:0] at SP−3.
- R5: Call (cmd_op 2) and register-pair save (cmd_op 1) write cmd_word[15:8] at SP−1 and then cmd_word[7:0] at SP−2.
- R6: Return (cmd_op 5) and register-pair restore (cmd_op 4) read pop_word[7:0] from SP and pop_word[15:8] from SP+1. The pointer increments after each read and ends at SP+2.
- R7: Interrupt return (cmd_op 6) reads pop_word[7:0] from SP, pop_word[15:8] from SP+1 and pop_stat from SP+2, and ends at SP+3.
- R8: Decrementing from 0xFB00 gives 0xFEFF.
- R9: Incrementing from 0xFEFF gives 0xFB00.
- R10: The block moves exactly one byte per cycle, and busy is high for exactly the frame length in cycles. Commands and pointer loads presented while busy is high are ignored.
- R11: done is high for exactly one cycle, the cycle after the last byte. pop_word and pop_stat hold their values until a later restore frame changes them.
- R12: cmd_op codes 0 and 7 are ignored. If a pointer load and a command arrive in the same idle cycle, the load is taken and the command is dropped.
- R13: mem_we and mem_re are never high together, and whenever either is high, mem_addr lies inside 0xFB00..0xFEFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (1 save pair, 2 call, 3 interrupt, 4 restore pair, 5 return, 6 interrupt return) |
| cmd_word | input | 16 | Register pair or return address to save |
| cmd_stat | input | 8 | Status byte saved on interrupt entry |
| sp_load | input | 1 | Pointer load strobe |
| sp_load_val | input | 16 | Value to load into the pointer |
| mem_addr | output | 16 | Stack memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as mem_re |
| pop_word | output | 16 | Restored word |
| pop_stat | output | 8 | Restored status byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sp_ready | output | 1 | Pointer has been loaded since reset |
| sp_value | output | 16 | Current folded pointer |

## Verification
A wrong step counter or frame plan shows up in the same cycle as a misplaced byte on mem_addr or mem_wdata. It then shows up on sp_value and as a wrong busy length when done arrives. A corrupted pointer index appears at once on sp_value, because that output is the index mapped into the window. Every save frame is replayed by its matching restore frame, so a byte-order or wrap error surfaces at the latest as a wrong pop_word or pop_stat two or three cycles after the restore starts. The window and exclusivity properties are checked every cycle, so an out-of-window address is caught in the cycle it appears.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_SAVE_RP = 3'd1,
        OP_CALL    = 3'd2,
        OP_INTR    = 3'd3,
        OP_REST_RP = 3'd4,
        OP_RET     = 3'd5,
        OP_RETI    = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_STAT = 2'd2
    } sel_e;

endpackage

// File: rtl/sfs_win_ptr.sv
// Maps between a window-relative index and a full address and computes the
// neighbouring indices. Wrap is implicit in the IDX_W-bit arithmetic.
module sfs_win_ptr #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hFB00
) (
    input  logic [ADDR_W-1:0] load_val,
    input  logic [IDX_W-1:0]  idx,
    output logic [IDX_W-1:0]  load_idx,
    output logic [IDX_W-1:0]  idx_inc,
    output logic [IDX_W-1:0]  idx_dec,
    output logic [ADDR_W-1:0] addr_cur,
    output logic [ADDR_W-1:0] addr_dec
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    assign load_idx = IDX_W'(load_val - WIN_BASE);
    assign idx_inc  = idx + ONE;
    assign idx_dec  = idx - ONE;
    assign addr_cur = WIN_BASE + ADDR_W'(idx);
    assign addr_dec = WIN_BASE + ADDR_W'(idx_dec);
endmodule

// File: rtl/sfs_frame_plan.sv
// For a command and a byte step, tells the direction, which field the byte
// belongs to, and whether the step is the last one of the frame.
module sfs_frame_plan
    import sfs_pkg::*;
(
    input  op_e        op,
    input  logic [1:0] step,
    output logic       is_save,
    output sel_e       sel,
    output logic       last
);
    logic [1:0] len;

    always_comb begin
        is_save = 1'b0;
        len     = 2'd2;
        sel     = SEL_LO;
        unique case (op)
            OP_INTR: begin
                is_save = 1'b1;
                len     = 2'd3;
                sel     = (step == 2'd0) ? SEL_STAT :
                          (step == 2'd1) ? SEL_HI : SEL_LO;
            end
            OP_CALL, OP_SAVE_RP: begin
                is_save = 1'b1;
                sel     = (step == 2'd0) ? SEL_HI : SEL_LO;
            end
            OP_RETI: begin
                len = 2'd3;
                sel = (step == 2'd0) ? SEL_LO :
                      (step == 2'd1) ? SEL_HI : SEL_STAT;
            end
            OP_RET, OP_REST_RP: begin
                sel = (step == 2'd0) ? SEL_LO : SEL_HI;
            end
            default: begin
                is_save = 1'b0;
                len     = 2'd2;
                sel     = SEL_LO;
            end
        endcase
        last = (step == (len - 2'd1));
    end
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
    import sfs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hFB00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [2*DATA_W-1:0] cmd_word,
    input  logic [DATA_W-1:0]   cmd_stat,
    input  logic                sp_load,
    input  logic [ADDR_W-1:0]   sp_load_val,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [2*DATA_W-1:0] pop_word,
    output logic [DATA_W-1:0]   pop_stat,
    output logic                busy,
    output logic                done,
    output logic                sp_ready,
    output logic [ADDR_W-1:0]   sp_value
);
    localparam int unsigned WORD_W = 2 * DATA_W;

    typedef struct packed {
        logic              ready;
        logic              busy;
        logic              done;
        op_e               op;
        logic [1:0]        step;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] stat;
        logic [WORD_W-1:0] pw;
        logic [DATA_W-1:0] ps;
    } st_t;

    st_t s_d, s_q;

    logic [IDX_W-1:0]  load_idx, idx_inc, idx_dec;
    logic [ADDR_W-1:0] addr_cur, addr_dec;
    logic              is_save, last;
    sel_e              sel;
    op_e               op_in;
    logic              op_ok;

    sfs_win_ptr #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .WIN_BASE (WIN_BASE)
    ) u_ptr (
        .load_val (sp_load_val),
        .idx      (s_q.idx),
        .load_idx (load_idx),
        .idx_inc  (idx_inc),
        .idx_dec  (idx_dec),
        .addr_cur (addr_cur),
        .addr_dec (addr_dec)
    );

    sfs_frame_plan u_plan (
        .op      (s_q.op),
        .step    (s_q.step),
        .is_save (is_save),
        .sel     (sel),
        .last    (last)
    );

    assign op_in = op_e'(cmd_op);
    assign op_ok = (op_in != OP_NONE) && (op_in != OP_RSVD);

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        mem_addr  = addr_cur;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;

        if (!s_q.busy) begin
            if (sp_load) begin
                s_d.idx   = load_idx;
                s_d.ready = 1'b1;
            end else if (cmd_valid && s_q.ready && op_ok) begin
                s_d.busy = 1'b1;
                s_d.op   = op_in;
                s_d.step = 2'd0;
                s_d.word = cmd_word;
                s_d.stat = cmd_stat;
            end
        end else begin
            if (is_save) begin
                mem_we   = 1'b1;
                mem_addr = addr_dec;
                unique case (sel)
                    SEL_STAT: mem_wdata = s_q.stat;
                    SEL_HI:   mem_wdata = s_q.word[WORD_W-1:DATA_W];
                    default:  mem_wdata = s_q.word[DATA_W-1:0];
                endcase
                s_d.idx = idx_dec;
            end else begin
                mem_re   = 1'b1;
                mem_addr = addr_cur;
                unique case (sel)
                    SEL_STAT: s_d.ps = mem_rdata;
                    SEL_HI:   s_d.pw[WORD_W-1:DATA_W] = mem_rdata;
                    default:  s_d.pw[DATA_W-1:0] = mem_rdata;
                endcase
                s_d.idx = idx_inc;
            end
            if (last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.step = s_q.step + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ready: 1'b0, busy: 1'b0, done: 1'b0, op: OP_NONE,
                     step: '0, idx: '0, word: '0, stat: '0, pw: '0, ps: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pop_word = s_q.pw;
    assign pop_stat = s_q.ps;
    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign sp_ready = s_q.ready;
    assign sp_value = addr_cur;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hFB00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              busy,
    input logic              done,
    input logic              sp_ready,
    input logic [ADDR_W-1:0] sp_value
);
    localparam logic [ADDR_W-1:0] WIN_TOP = WIN_BASE + ADDR_W'((1 << IDX_W) - 1);

    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R13
    AST_ADDR_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr >= WIN_BASE && mem_addr <= WIN_TOP)); // R13
    AST_SP_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        sp_value >= WIN_BASE && sp_value <= WIN_TOP); // R1
    AST_IDLE_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_ready |-> (!busy && !mem_we && !mem_re)); // R2
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sp_ready |=> sp_ready); // R2
    AST_PREDEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_value == $past(mem_addr)); // R3
    AST_POSTINC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_value == (($past(mem_addr) == WIN_TOP) ? WIN_BASE
                                : $past(mem_addr) + ADDR_W'(1))); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy) && !busy); // R11
endmodule

bind stack_frame_seq sfs_checker #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .busy     (busy),
    .done     (done),
    .sp_ready (sp_ready),
    .sp_value (sp_value)
);

// File: tb/stack_frame_seq_tb.sv
`timescale 1ns/1ps
module stack_frame_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  cmd_stat = '0;
    logic        sp_load = 1'b0;
    logic [15:0] sp_load_val = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [7:0]  mem_rdata;
    logic [15:0] pop_word;
    logic [7:0]  pop_stat;
    logic        busy, done, sp_ready;
    logic [15:0] sp_value;

    always #2.5 clk = ~clk;

    stack_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .cmd_stat(cmd_stat), .sp_load(sp_load),
        .sp_load_val(sp_load_val), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .pop_word(pop_word), .pop_stat(pop_stat), .busy(busy), .done(done),
        .sp_ready(sp_ready), .sp_value(sp_value)
    );

    logic [7:0]  ram [1024];
    logic [15:0] rel;
    assign rel       = mem_addr - 16'hFB00;
    assign mem_rdata = ram[rel[9:0]];
    always @(posedge clk) if (mem_we) ram[rel[9:0]] <= mem_wdata;

    int total = 0, bad = 0;
    int we_cnt = 0, re_cnt = 0, done_cnt = 0, viol = 0, cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (mem_we) we_cnt++;
        if (mem_re) re_cnt++;
        if (done) done_cnt++;
        if ((mem_we && mem_re) ||
            ((mem_we || mem_re) && (mem_addr < 16'hFB00 || mem_addr > 16'hFEFF))) viol++;
        if (cyc == 100000) begin
            total++; bad++;
            $display("FAIL watchdog R10 act=%0d exp=<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    typedef struct packed {
        logic [15:0] init;
        logic [2:0]  op;
        logic [15:0] word;
        logic [7:0]  stat;
        logic [15:0] fold;
        logic [15:0] after;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'hFF00, 3'd3, 16'h1234, 8'hA5, 16'hFB00, 16'hFEFD},
        '{16'hFE80, 3'd2, 16'hBEEF, 8'h00, 16'hFE80, 16'hFE7E},
        '{16'hFC01, 3'd1, 16'h55AA, 8'h00, 16'hFC01, 16'hFBFF},
        '{16'h0301, 3'd2, 16'h0F0E, 8'h00, 16'hFB01, 16'hFEFF},
        '{16'h1B01, 3'd3, 16'h8421, 8'h3C, 16'hFB01, 16'hFEFE},
        '{16'h2AFF, 3'd1, 16'hC33C, 8'h00, 16'hFEFF, 16'hFEFD}
    };

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] waddr(logic [15:0] base, int k);
        logic [15:0] d;
        d = base - 16'hFB00 + 16'(k);
        return 16'hFB00 + {6'b0, d[9:0]};
    endfunction

    function automatic logic [7:0] rd(logic [15:0] a);
        logic [15:0] d;
        d = a - 16'hFB00;
        return ram[d[9:0]];
    endfunction

    task automatic load(logic [15:0] v);
        sp_load = 1'b1; sp_load_val = v;
        tick();
        sp_load = 1'b0;
    endtask

    task automatic run_cmd(logic [2:0] op, logic [15:0] w, logic [7:0] st, output int nbusy);
        int guard;
        cmd_valid = 1'b1; cmd_op = op; cmd_word = w; cmd_stat = st;
        tick();
        cmd_valid = 1'b0;
        nbusy = 0; guard = 0;
        while (!done && guard < 20) begin
            if (busy) nbusy++;
            tick();
            guard++;
        end
    endtask

    initial begin
        int nb, d0, w0, r0;
        for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        chk("R2", {29'b0, sp_ready, busy, done}, 32'h0, "reset ready/busy/done");

        w0 = we_cnt; d0 = done_cnt;
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_word = 16'hAAAA;
        tick(); cmd_valid = 1'b0;
        repeat (4) tick();
        chk("R2", we_cnt - w0, 0, "writes before load");
        chk("R2", done_cnt - d0, 0, "done before load");

        for (int i = 0; i < 6; i++) begin
            vec_t v;
            logic [2:0] pop_op;
            int len;
            v = VECS[i];
            len = (v.op == 3'd3) ? 3 : 2;
            pop_op = (v.op == 3'd3) ? 3'd6 : (v.op == 3'd2) ? 3'd5 : 3'd4;
            load(v.init);
            chk("R1", sp_value, v.fold, "folded load");
            d0 = done_cnt;
            run_cmd(v.op, v.word, v.stat, nb);
            chk("R10", nb, len, "save busy cycles");
            chk("R3 R8", sp_value, v.after, "pointer after save");
            if (len == 3) begin
                chk("R4", rd(waddr(v.fold, -1)), v.stat, "status at SP-1");
                chk("R4", rd(waddr(v.fold, -2)), v.word[15:8], "high at SP-2");
                chk("R4", rd(waddr(v.fold, -3)), v.word[7:0], "low at SP-3");
            end else begin
                chk("R5", rd(waddr(v.fold, -1)), v.word[15:8], "high at SP-1");
                chk("R5", rd(waddr(v.fold, -2)), v.word[7:0], "low at SP-2");
            end
            tick();
            chk("R11", {31'b0, done}, 0, "done width");
            chk("R11", done_cnt - d0, 1, "done count save");
            run_cmd(pop_op, 16'h0, 8'h0, nb);
            chk("R10", nb, len, "restore busy cycles");
            chk("R6 R7 R9", sp_value, v.fold, "pointer after restore");
            chk("R6", pop_word, v.word, "restored word");
            if (len == 3) chk("R7", pop_stat, v.stat, "restored status");
            tick();
        end

        load(16'hFC80);
        w0 = we_cnt; r0 = re_cnt;
        for (int k = 0; k < 2; k++) begin
            cmd_valid = 1'b1; cmd_op = (k == 0) ? 3'd0 : 3'd7;
            tick(); cmd_valid = 1'b0;
            tick();
            chk("R12", {31'b0, busy}, 0, "reserved op busy");
        end
        chk("R12", (we_cnt - w0) + (re_cnt - r0), 0, "reserved op accesses");
        chk("R12", sp_value, 16'hFC80, "reserved op pointer");

        w0 = we_cnt;
        sp_load = 1'b1; sp_load_val = 16'hFE00;
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_word = 16'h9999;
        tick();
        sp_load = 1'b0; cmd_valid = 1'b0;
        tick();
        chk("R12", sp_value, 16'hFE00, "load wins");
        chk("R12", we_cnt - w0, 0, "dropped command");

        load(16'hFD00);
        w0 = we_cnt; d0 = done_cnt;
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_word = 16'h2211;
        tick();
        cmd_op = 3'd3; cmd_word = 16'h5555;
        sp_load = 1'b1; sp_load_val = 16'hFC00;
        tick();
        cmd_valid = 1'b0; sp_load = 1'b0;
        repeat (4) tick();
        chk("R10", sp_value, 16'hFCFE, "ignored while busy pointer");
        chk("R10", we_cnt - w0, 2, "ignored while busy writes");
        chk("R10", rd(16'hFCFF), 8'h22, "first frame byte");
        chk("R11", done_cnt - d0, 1, "single done");

        run_cmd(3'd2, 16'h7777, 8'h00, nb);
        chk("R11", pop_word, 16'hC33C, "restored word held");

        chk("R13", viol, 0, "access exclusivity and window");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule